// File: doc/BRIEF.md
# Serial Port Interrupt Controller

This block is the interrupt front end of a byte-wide serial port. Five status sources feed it: a line error pulse, the receive buffer fill level, the receive buffer activity strobes, the transmit holding register empty level and a modem line change pulse. It keeps sticky flags for the event sources and compares the fill level against a programmable trigger level. It also times receive idle periods in units of character times. The pending sources that are enabled are ranked by a fixed priority. The highest one is shown in an identification register, and a single active-high interrupt output is driven.

Software reaches the block through a byte-wide bus with separate read and write strobes. It writes the enable mask and the trigger level select, and it reads the identification register. Some reads and writes also act as acknowledgements. These are reads of the line status and modem status addresses, reads of the receive data address, and writes of the transmit data address. The data path, the baud generator and the buffers live outside this block and are seen only through the status inputs.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the identification register reads 0xC1, the enable register reads 0x00, the trigger level is 14 bytes and `irq` is low.
- R2: The enable register sits at address 1. Bits 3:0 are read/write: bit 0 enables receive data and timeout, bit 1 transmit empty, bit 2 line status and bit 3 modem status. Bits 7:4 always read 0.
- R3: The identification register at address 2 reads {2'b11, 2'b00, code[2:0], nopend}. Here nopend is 0 when an enabled source is pending and 1 otherwise, and `irq` is high exactly when nopend is 0.
- R4: A `line_err` pulse raises the line status source (code 011). It has the highest priority and is cleared by a read of address 5.
- R5: The receive data source (code 010) is reported while `rx_level` is at or above the trigger level. It disappears once the level falls below it.
- R6: A write to address 2 selects the trigger level with data bits 7:6: 00 gives 1 byte, 01 gives 4 bytes, 10 gives 8 bytes and 11 gives 14 bytes.
- R7: The timeout source (code 110) is raised when `rx_level` is nonzero and no receive read and no `rx_push` has occurred for 4×`char_ticks` baud ticks. A read of address 0 clears it, and a read or a push restarts the count.
- R8: When receive data and timeout are both pending, code 010 is reported.
- R9: A rising edge of `tx_empty` raises the transmit empty source (code 001), third in priority. It is cleared by a write to address 0, or by a read of address 2 that returns code 001.
- R10: A `modem_delta` pulse raises the modem source (code 000), which has the lowest priority. It is cleared by a read of address 6.
- R11: A source whose enable bit is 0 never makes `irq` high and is never reported. Its flag is kept, so setting the enable bit later reports it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_rdata | output | 8 | Read data (combinational) |
| line_err | input | 1 | Parity, overrun, framing or break event pulse |
| rx_level | input | 5 | Receive buffer character count |
| rx_push | input | 1 | New character entered the receive buffer |
| tx_empty | input | 1 | Transmit holding register empty level |
| modem_delta | input | 1 | Modem line change pulse |
| baud_tick | input | 1 | Baud tick enable |
| char_ticks | input | 16 | Baud ticks per character |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the overlap of sources. All five must be pending at once, and they must then retire one by one in the order set by priority. The receive timeout makes this harder because it appears only after a long idle window. The bench shortens that window by setting `char_ticks` to 2 with the baud tick held high. It then walks the level above and below the trigger while the timeout flag is held, so the tie between codes 010 and 110 is shown in both directions. A large `char_ticks` keeps the timeout quiet during the full-priority test, so the five-source order can be observed alone.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam logic [2:0] ADDR_DATA = 3'd0;
  localparam logic [2:0] ADDR_MASK = 3'd1;
  localparam logic [2:0] ADDR_IDFC = 3'd2;
  localparam logic [2:0] ADDR_LINE = 3'd5;
  localparam logic [2:0] ADDR_MDM  = 3'd6;

  typedef enum logic [2:0] {
    SRC_MODEM = 3'b000,
    SRC_THRE  = 3'b001,
    SRC_RXDAT = 3'b010,
    SRC_LINE  = 3'b011,
    SRC_TMO   = 3'b110
  } src_code_e;
endpackage

// File: rtl/uart_irq_regs.sv
module uart_irq_regs #(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_wr,
  input  logic          trig_wr,
  input  logic [7:0]    wdata,
  output logic [3:0]    ier_q,
  output logic [LW-1:0] trig_lvl
);
  logic [3:0] ier_d;
  logic [1:0] sel_q, sel_d;

  always_comb begin
    ier_d = ier_q;
    sel_d = sel_q;
    if (mask_wr) ier_d = wdata[3:0];
    if (trig_wr) sel_d = wdata[7:6];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q <= '0;
      sel_q <= 2'b11;
    end else begin
      ier_q <= ier_d;
      sel_q <= sel_d;
    end
  end

  always_comb begin
    case (sel_q)
      2'b00:   trig_lvl = LW'(1);
      2'b01:   trig_lvl = LW'(4);
      2'b10:   trig_lvl = LW'(8);
      default: trig_lvl = LW'(14);
    endcase
  end
endmodule

// File: rtl/uart_irq_flags.sv
module uart_irq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic line_err,
  input  logic line_ack,
  input  logic tx_empty,
  input  logic thr_wr,
  input  logic thre_ack,
  input  logic modem_delta,
  input  logic modem_ack,
  output logic line_q,
  output logic thre_q,
  output logic modem_q
);
  logic line_d, thre_d, modem_d, txe_q;

  always_comb begin
    line_d  = line_err | (line_q & ~line_ack);
    modem_d = modem_delta | (modem_q & ~modem_ack);
    thre_d  = (tx_empty & ~txe_q) | (thre_q & ~thr_wr & ~thre_ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= 1'b0;
      thre_q  <= 1'b0;
      modem_q <= 1'b0;
      txe_q   <= 1'b0;
    end else begin
      line_q  <= line_d;
      thre_q  <= thre_d;
      modem_q <= modem_d;
      txe_q   <= tx_empty;
    end
  end
endmodule

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
  parameter int LW = 5,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic [CW-1:0] char_ticks,
  input  logic [LW-1:0] rx_level,
  input  logic          rx_push,
  input  logic          fifo_rd,
  output logic          tmo_q
);
  localparam int TW = CW + 2;

  logic [TW-1:0] cnt_q, cnt_d, limit;
  logic          restart, fire, tmo_d;

  always_comb begin
    limit   = {char_ticks, 2'b00};
    restart = fifo_rd | rx_push | (rx_level == '0);
    if (restart)                        cnt_d = '0;
    else if (baud_tick && cnt_q != limit) cnt_d = cnt_q + TW'(1);
    else                                cnt_d = cnt_q;
    fire  = !restart && (cnt_q == limit);
    tmo_d = fire | (tmo_q & ~fifo_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tmo_q <= tmo_d;
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [3:0] ier,
  input  logic       line_pend,
  input  logic       rxdat_pend,
  input  logic       tmo_pend,
  input  logic       thre_pend,
  input  logic       modem_pend,
  output logic       any_pend,
  output logic [2:0] code
);
  always_comb begin
    any_pend = 1'b1;
    code     = SRC_MODEM;
    if (ier[2] && line_pend)       code = SRC_LINE;
    else if (ier[0] && rxdat_pend) code = SRC_RXDAT;
    else if (ier[0] && tmo_pend)   code = SRC_TMO;
    else if (ier[1] && thre_pend)  code = SRC_THRE;
    else if (ier[3] && modem_pend) code = SRC_MODEM;
    else                           any_pend = 1'b0;
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int LW = 5,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [7:0]    bus_rdata,
  input  logic          line_err,
  input  logic [LW-1:0] rx_level,
  input  logic          rx_push,
  input  logic          tx_empty,
  input  logic          modem_delta,
  input  logic          baud_tick,
  input  logic [CW-1:0] char_ticks,
  output logic          irq
);
  logic [3:0]    ier_q;
  logic [LW-1:0] trig_lvl;
  logic          line_q, thre_q, modem_q, tmo_q;
  logic          any_pend;
  logic [2:0]    code;
  logic [7:0]    ident;
  logic          fifo_rd, thr_wr, id_rd;

  always_comb begin
    fifo_rd = bus_rd && bus_addr == ADDR_DATA;
    thr_wr  = bus_wr && bus_addr == ADDR_DATA;
    id_rd   = bus_rd && bus_addr == ADDR_IDFC;
  end

  uart_irq_regs #(.LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .mask_wr(bus_wr && bus_addr == ADDR_MASK),
    .trig_wr(bus_wr && bus_addr == ADDR_IDFC),
    .wdata(bus_wdata), .ier_q(ier_q), .trig_lvl(trig_lvl)
  );

  uart_irq_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .line_err(line_err),
    .line_ack(bus_rd && bus_addr == ADDR_LINE),
    .tx_empty(tx_empty), .thr_wr(thr_wr),
    .thre_ack(id_rd && code == SRC_THRE && any_pend),
    .modem_delta(modem_delta),
    .modem_ack(bus_rd && bus_addr == ADDR_MDM),
    .line_q(line_q), .thre_q(thre_q), .modem_q(modem_q)
  );

  uart_irq_timeout #(.LW(LW), .CW(CW)) u_tmo (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .char_ticks(char_ticks), .rx_level(rx_level),
    .rx_push(rx_push), .fifo_rd(fifo_rd), .tmo_q(tmo_q)
  );

  uart_irq_prio u_prio (
    .ier(ier_q), .line_pend(line_q),
    .rxdat_pend(rx_level >= trig_lvl), .tmo_pend(tmo_q),
    .thre_pend(thre_q), .modem_pend(modem_q),
    .any_pend(any_pend), .code(code)
  );

  always_comb begin
    ident = {2'b11, 2'b00, code, ~any_pend};
    irq   = any_pend;
    case (bus_addr)
      ADDR_MASK: bus_rdata = {4'b0000, ier_q};
      ADDR_IDFC: bus_rdata = ident;
      default:   bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] bus_addr,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic [7:0] bus_rdata,
  input logic       irq,
  input logic [3:0] ier,
  input logic [7:0] ident,
  input logic       line_q,
  input logic       thre_q,
  input logic       modem_q,
  input logic       tmo_q,
  input logic       line_err,
  input logic       tx_empty,
  input logic       modem_delta
);
  // R3
  irq_vs_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd2) |-> (irq == !bus_rdata[0]));
  // R2
  mask_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd1) |-> (bus_rdata[7:4] == 4'h0));
  // R4
  line_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q && ier[2]) |-> (ident[3:0] == 4'b0110));
  // R4
  line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd5 && !line_err) |=> !line_q);
  // R7
  tmo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd0) |=> !tmo_q);
  // R9
  thre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0 && !tx_empty) |=> !thre_q);
  // R10
  modem_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd6 && !modem_delta) |=> !modem_q);
  // R11
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == 4'h0) |-> !irq);
endmodule

bind uart_irq_ctrl uart_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_rdata(bus_rdata), .irq(irq), .ier(ier_q),
  .ident(ident), .line_q(line_q), .thre_q(thre_q), .modem_q(modem_q),
  .tmo_q(tmo_q), .line_err(line_err), .tx_empty(tx_empty),
  .modem_delta(modem_delta)
);

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_rdata;
  logic        line_err, rx_push, tx_empty, modem_delta, baud_tick;
  logic [4:0]  rx_level;
  logic [15:0] char_ticks;
  logic        irq;
  int          checks = 0;
  int          fails = 0;
  int          cyc = 0;
  logic [7:0]  d;

  // {trigger select, level, expected ident} walked against R5/R6
  localparam logic [15:0] VEC [8] = '{
    {2'b00, 6'd0,  8'hC1}, {2'b00, 6'd1,  8'hC4},
    {2'b01, 6'd3,  8'hC1}, {2'b01, 6'd4,  8'hC4},
    {2'b10, 6'd7,  8'hC1}, {2'b10, 6'd8,  8'hC4},
    {2'b11, 6'd13, 8'hC1}, {2'b11, 6'd14, 8'hC4}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .line_err(line_err), .rx_level(rx_level), .rx_push(rx_push),
    .tx_empty(tx_empty), .modem_delta(modem_delta), .baud_tick(baud_tick),
    .char_ticks(char_ticks), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
    #1;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      checks++; fails++;
      $display("FAIL watchdog actual %0d expected done", cyc);
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    line_err = 1'b0; rx_push = 1'b0; tx_empty = 1'b0; modem_delta = 1'b0;
    baud_tick = 1'b1; rx_level = '0; char_ticks = 16'd100;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(3'd2, d); chk("R1 ident", d, 8'hC1);
    rd(3'd1, d); chk("R1 ier", d, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    wr(3'd1, 8'h01);
    rx_level = 5'd13; #1;
    rd(3'd2, d); chk("R1 trig14 below", d, 8'hC1);
    rx_level = 5'd14; #1;
    rd(3'd2, d); chk("R1 trig14 at", d, 8'hC4);
    rx_level = 5'd0;

    // R2 reserved bits
    wr(3'd1, 8'hFF);
    rd(3'd1, d); chk("R2 ier rsv", d, 8'h0F);
    wr(3'd1, 8'h01);

    // R5/R6 vector walk
    foreach (VEC[i]) begin
      wr(3'd2, {VEC[i][15:14], 6'b0});
      rx_level = VEC[i][12:8]; #1;
      rd(3'd2, d); chk($sformatf("R6 R5 vec%0d", i), d, VEC[i][7:0]);
      chk($sformatf("R3 irq vec%0d", i), {7'b0, irq}, {7'b0, ~VEC[i][0]});
    end
    rx_level = 5'd0;
    wr(3'd2, 8'hC0);

    // R4 R5 R9 R10 full priority walk
    pulse(line_err);
    pulse(modem_delta);
    tx_empty = 1'b1;
    rx_level = 5'd14;
    wr(3'd1, 8'h0F);
    rd(3'd2, d); chk("R4 top", d, 8'hC6);
    rd(3'd5, d);
    rd(3'd2, d); chk("R5 after lsr", d, 8'hC4);
    rx_level = 5'd0; #1;
    rd(3'd2, d); chk("R9 thre shown", d, 8'hC2);
    rd(3'd2, d); chk("R10 after id read", d, 8'hC0);
    rd(3'd6, d);
    rd(3'd2, d); chk("R10 cleared", d, 8'hC1);
    chk("R3 irq low", {7'b0, irq}, 8'h00);

    // R11 masked source kept
    wr(3'd1, 8'h00);
    pulse(modem_delta);
    chk("R11 masked irq", {7'b0, irq}, 8'h00);
    rd(3'd2, d); chk("R11 masked id", d, 8'hC1);
    wr(3'd1, 8'h08);
    rd(3'd2, d); chk("R11 enabled", d, 8'hC0);
    rd(3'd6, d);

    // R9 cleared by data write
    tx_empty = 1'b0;
    wr(3'd1, 8'h02);
    @(negedge clk); tx_empty = 1'b1;
    idle(2);
    chk("R9 irq set", {7'b0, irq}, 8'h01);
    wr(3'd0, 8'h55);
    tx_empty = 1'b0;
    chk("R9 thr write", {7'b0, irq}, 8'h00);

    // R7 R8 timeout
    wr(3'd1, 8'h01);
    char_ticks = 16'd2;
    @(negedge clk); rx_level = 5'd2; rx_push = 1'b1;
    @(negedge clk); rx_push = 1'b0;
    idle(6);
    rd(3'd2, d); chk("R7 early", d, 8'hC1);
    idle(3);
    rd(3'd2, d); chk("R7 fired", d, 8'hCC);
    rx_level = 5'd14; #1;
    rd(3'd2, d); chk("R8 rxdat wins", d, 8'hC4);
    rx_level = 5'd2; #1;
    rd(3'd2, d); chk("R8 tmo back", d, 8'hCC);
    rd(3'd0, d);
    rd(3'd2, d); chk("R7 read clears", d, 8'hC1);
    rx_level = 5'd0;
    idle(2);
    summary();
  end
endmodule